// File: doc/BRIEF.md
# Translation Buffer with Hardware Table Walk

This block converts a virtual address into a physical address. The virtual address is split into a page number and an in-page offset. A small fully associative buffer caches recent page table entries. When the buffer holds the page, the physical address is the cached frame number with the offset appended unchanged. When it does not, the block fetches the entry itself from a flat page table in memory, then replays the same access against the buffer.

An entry fetched with its resident bit clear is not cached. The block instead returns a page-fault response that carries the virtual address. The requester sees the fault before any translated address, so it never writes a destination with a bad translation. A write to a page without write permission returns a protection fault. The buffer copy of each entry records that the page was referenced. The first permitted write to a clean page marks the copy dirty and stores the updated entry back to the table. Only one access is in flight at a time: the request port stalls while a table read or write-back is pending.

Top module: `xlat_unit`

## Requirements
- R1: A hit returns `resp_valid` one cycle after the request is accepted, with `resp_paddr` = {frame number, offset}. The low 4 bits of the virtual address pass through unchanged, and the frame number sits above them.
- R2: On a miss the block raises `mem_req` with `mem_we`=0 at address `pt_base` + page number × 2. It holds the request and its address stable until `mem_ack`. `req_ready` stays low whenever a memory request is pending.
- R3: A fetched entry whose resident bit (bit 15) is set is installed, and the access is replayed and translated. Any later access to the same page hits without a memory request, and no page matches two entries.
- R4: A fetched entry whose resident bit is clear gives a response with `resp_page_fault`=1, `resp_prot_fault`=0, `resp_paddr`=0 and `resp_vaddr` equal to the faulting address. It is not installed, so the next access to that page walks again. This also applies to writes.
- R5: A write to a page whose write-permission bit (bit 14) is clear responds with `resp_prot_fault`=1, `resp_page_fault`=0 and `resp_paddr`=0. It writes no memory. A read of the same page still translates normally.
- R6: A permitted write to a page whose dirty bit (bit 13) is clear in the buffer sets that bit. It then issues one memory write to the entry's own address. The data written has bits 15, 13 and 12 (referenced) set, keeps bit 14, and has the frame number in bits 7:0. Later writes to that page, and writes to pages fetched already dirty, issue no memory write.
- R7: Refills replace the 8 entries in round-robin order starting at entry 0. After 9 distinct pages are filled, the first page misses and the other 8 hit.
- R8: A `flush` pulse invalidates every entry in one cycle, so the next access to any page walks the table again.
- R9: Out of reset `req_ready`=1, `resp_valid`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | 16 | Byte address of the page table |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | Access is a write |
| req_vaddr | input | 12 | Virtual address (page 11:4, offset 3:0) |
| resp_valid | output | 1 | Response present for one cycle |
| resp_paddr | output | 12 | Physical address, zero on any fault |
| resp_vaddr | output | 12 | Virtual address of the answered access |
| resp_page_fault | output | 1 | Page not resident |
| resp_prot_fault | output | 1 | Access not permitted |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Memory request is a write-back |
| mem_addr | output | 16 | Entry address |
| mem_wdata | output | 16 | Entry data for write-back |
| mem_ack | input | 1 | Memory completes request (one cycle) |
| mem_rdata | input | 16 | Entry data read, valid with `mem_ack` |

## Verification
Some properties are checked on every cycle by assertions:
- at most one buffer entry matches any page;
- a flush leaves the buffer empty on the next cycle;
- memory requests stay stable until acknowledged, and the request port is blocked while one is pending;
- a successful translation keeps the offset;
- a response never shows both fault kinds at once;
- a write-back starts only alongside a successful translation.

Other behaviour shows only in the bench's scenarios:
- the frame numbers themselves;
- which accesses cause table walks;
- round-robin eviction order;
- the contents of write-backs;
- that faulting entries are not cached.

The bench sweeps every page of the table with read accesses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 8;
  localparam int PFN_W = 8;
  localparam int OFF_W = 4;
  localparam int PTE_W = 16;
  localparam int MA_W  = 16;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  typedef struct packed {
    logic             valid;
    logic             wr;
    logic             dirty;
    logic             refd;
    logic [PFN_W-1:0] pfn;
  } pte_t;

  // Memory word: [15] resident, [14] writable, [13] dirty, [12] referenced, [PFN_W-1:0] frame
  function automatic pte_t pte_unpack(input logic [PTE_W-1:0] w);
    pte_t p;
    p.valid = w[PTE_W-1];
    p.wr    = w[PTE_W-2];
    p.dirty = w[PTE_W-3];
    p.refd  = w[PTE_W-4];
    p.pfn   = w[PFN_W-1:0];
    return p;
  endfunction

  function automatic logic [PTE_W-1:0] pte_pack(input pte_t p);
    logic [PTE_W-1:0] w;
    w = '0;
    w[PTE_W-1]   = p.valid;
    w[PTE_W-2]   = p.wr;
    w[PTE_W-3]   = p.dirty;
    w[PTE_W-4]   = p.refd;
    w[PFN_W-1:0] = p.pfn;
    return w;
  endfunction

  function automatic logic [MA_W-1:0] pte_addr(input logic [MA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn,
                                               input int bytes);
    return base + MA_W'(vpn) * MA_W'(bytes);
  endfunction

  function automatic logic [PA_W-1:0] make_paddr(input logic [PFN_W-1:0] pfn,
                                                 input logic [VA_W-1:0] va);
    return {pfn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             touch_en,
  input  logic             touch_dirty,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  pte_t             ins_pte,
  output logic             hit,
  output pte_t             hit_pte
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]        vld_q;
  logic [ENTRIES-1:0]        match;
  pte_t [ENTRIES-1:0]        ent_q;
  logic [IW-1:0]             rr_q;

  genvar i;
  generate
    for (i = 0; i < ENTRIES; i++) begin : g_ent
      logic             v_q;
      logic [VPN_W-1:0] tag_q;
      pte_t             e_q;
      logic             fill_me;
      assign fill_me  = ins_en && (rr_q == IW'(i));
      assign match[i] = v_q && (tag_q == look_vpn);
      assign vld_q[i] = v_q;
      assign ent_q[i] = e_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          tag_q <= '0;
          e_q   <= '0;
        end else if (flush) begin
          v_q <= 1'b0;
        end else if (fill_me) begin
          v_q     <= 1'b1;
          tag_q   <= ins_vpn;
          e_q     <= ins_pte;
          e_q.refd <= 1'b1;
        end else if (touch_en && match[i]) begin
          e_q.refd <= 1'b1;
          if (touch_dirty) e_q.dirty <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    hit_pte = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (match[k]) hit_pte = pte_t'(hit_pte | ent_q[k]);
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (ins_en && !flush) rr_q <= (rr_q == IW'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R8
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
  import xlat_pkg::*;
#(
  parameter int ENTRY_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             hit,
  input  pte_t             hit_pte,
  output logic [VPN_W-1:0] look_vpn,
  output logic             touch_en,
  output logic             touch_dirty,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output pte_t             ins_pte,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [VA_W-1:0]  resp_vaddr,
  output logic             resp_page_fault,
  output logic             resp_prot_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [MA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_RETRY, S_WBACK} st_t;
  st_t st_q;

  logic [VA_W-1:0]  sv_va_q;
  logic             sv_wr_q;
  logic [PTE_W-1:0] wb_q;

  logic [VA_W-1:0] cur_va;
  logic            cur_wr;
  logic            do_look, lookup_hit, prot_hit, need_wb;
  logic            walk_done, walk_fill, walk_fault;
  pte_t            fetched, wb_ent;

  assign cur_va     = (st_q == S_RETRY) ? sv_va_q : req_vaddr;
  assign cur_wr     = (st_q == S_RETRY) ? sv_wr_q : req_write;
  assign do_look    = (st_q == S_IDLE && req_valid) || (st_q == S_RETRY);
  assign lookup_hit = do_look && hit;
  assign prot_hit   = cur_wr && !hit_pte.wr;
  assign need_wb    = cur_wr && hit_pte.wr && !hit_pte.dirty;

  assign fetched    = pte_unpack(mem_rdata);
  assign walk_done  = (st_q == S_WALK) && mem_ack;
  assign walk_fill  = walk_done && fetched.valid;
  assign walk_fault = walk_done && !fetched.valid;

  always_comb begin
    wb_ent       = hit_pte;
    wb_ent.valid = 1'b1;
    wb_ent.dirty = 1'b1;
    wb_ent.refd  = 1'b1;
  end

  assign req_ready   = (st_q == S_IDLE);
  assign look_vpn    = cur_va[VA_W-1:OFF_W];
  assign touch_en    = lookup_hit;
  assign touch_dirty = lookup_hit && need_wb;
  assign ins_en      = walk_fill;
  assign ins_vpn     = sv_va_q[VA_W-1:OFF_W];
  assign ins_pte     = fetched;
  assign mem_req     = (st_q == S_WALK) || (st_q == S_WBACK);
  assign mem_we      = (st_q == S_WBACK);
  assign mem_addr    = pte_addr(pt_base, sv_va_q[VA_W-1:OFF_W], ENTRY_BYTES);
  assign mem_wdata   = wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q            <= S_IDLE;
      sv_va_q         <= '0;
      sv_wr_q         <= 1'b0;
      wb_q            <= '0;
      resp_valid      <= 1'b0;
      resp_paddr      <= '0;
      resp_vaddr      <= '0;
      resp_page_fault <= 1'b0;
      resp_prot_fault <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        S_IDLE, S_RETRY: begin
          if (do_look) begin
            sv_va_q <= cur_va;
            sv_wr_q <= cur_wr;
            if (hit) begin
              resp_valid      <= 1'b1;
              resp_vaddr      <= cur_va;
              resp_page_fault <= 1'b0;
              resp_prot_fault <= prot_hit;
              resp_paddr      <= prot_hit ? '0 : make_paddr(hit_pte.pfn, cur_va);
              if (need_wb) begin
                wb_q <= pte_pack(wb_ent);
                st_q <= S_WBACK;
              end else begin
                st_q <= S_IDLE;
              end
            end else begin
              st_q <= S_WALK;
            end
          end
        end
        S_WALK: begin
          if (walk_fill) st_q <= S_RETRY;
          else if (walk_fault) begin
            resp_valid      <= 1'b1;
            resp_vaddr      <= sv_va_q;
            resp_page_fault <= 1'b1;
            resp_prot_fault <= 1'b0;
            resp_paddr      <= '0;
            st_q            <= S_IDLE;
          end
        end
        default: if (mem_ack) st_q <= S_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_page_fault && !resp_prot_fault)
      |-> (resp_paddr[OFF_W-1:0] == resp_vaddr[OFF_W-1:0])); // R1
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_page_fault && resp_prot_fault)); // R5
  AST_WB_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (resp_valid && !resp_page_fault && !resp_prot_fault)); // R6
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [MA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [VA_W-1:0]  resp_vaddr,
  output logic             resp_page_fault,
  output logic             resp_prot_fault,
  output logic             mem_req,
  output logic             mem_we,
  output logic [MA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  logic [VPN_W-1:0] look_vpn, ins_vpn;
  logic             touch_en, touch_dirty, ins_en, hit;
  pte_t             ins_pte, hit_pte;

  xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush), .look_vpn(look_vpn),
    .touch_en(touch_en), .touch_dirty(touch_dirty), .ins_en(ins_en),
    .ins_vpn(ins_vpn), .ins_pte(ins_pte), .hit(hit), .hit_pte(hit_pte)
  );

  xlat_walk #(.ENTRY_BYTES(ENTRY_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .hit(hit), .hit_pte(hit_pte), .look_vpn(look_vpn),
    .touch_en(touch_en), .touch_dirty(touch_dirty), .ins_en(ins_en),
    .ins_vpn(ins_vpn), .ins_pte(ins_pte), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr),
    .resp_page_fault(resp_page_fault), .resp_prot_fault(resp_prot_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/xlat_unit_tb.sv
`timescale 1ns/1ps
module xlat_unit_tb;
  localparam logic [15:0] BASE = 16'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_vaddr = '0;
  logic req_ready, resp_valid, resp_page_fault, resp_prot_fault;
  logic [11:0] resp_paddr, resp_vaddr;
  logic mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  xlat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_vaddr(resp_vaddr), .resp_page_fault(resp_page_fault),
    .resp_prot_fault(resp_prot_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] pte_word(input int v);
    logic [15:0] w;
    w = '0;
    w[15] = (v % 5) != 3;
    w[14] = (v % 3) != 0;
    w[13] = (v % 7) == 0;
    w[7:0] = 8'(v) ^ 8'hA5;
    return w;
  endfunction

  logic [15:0] pt [256];
  int n_rd = 0, n_wr = 0;
  logic [15:0] last_ra = '0, last_wa = '0, last_wd = '0;
  logic [7:0] idx_w;
  assign idx_w = 8'((mem_addr - BASE) >> 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= pt[idx_w];
        if (mem_we) begin
          pt[idx_w] <= mem_wdata;
          n_wr <= n_wr + 1;
          last_wa <= mem_addr;
          last_wd <= mem_wdata;
        end else begin
          n_rd <= n_rd + 1;
          last_ra <= mem_addr;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [11:0] r_pa, r_va;
  logic r_pf, r_pr;

  task automatic access(input logic [11:0] va, input logic wr);
    logic rdy;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    while (1) begin
      rdy = req_ready;
      @(negedge clk);
      if (rdy) break;
    end
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    r_pa = resp_paddr; r_va = resp_vaddr; r_pf = resp_page_fault; r_pr = resp_prot_fault;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rd0, wr0;
    logic [15:0] w;
    logic [11:0] va;
    int pg[9];
    int k;
    for (int v = 0; v < 256; v++) pt[v] = pte_word(v);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 req_ready", 32'(req_ready), 32'd1);
    check("R9 resp_valid", 32'(resp_valid), 32'd0);
    check("R9 mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    // Sweep every page with reads: R1, R2, R3, R4
    for (int v = 0; v < 256; v++) begin
      w = pte_word(v);
      va = {8'(v), 4'(v) ^ 4'h6};
      rd0 = n_rd;
      access(va, 1'b0);
      check("R2 walk count", 32'(n_rd - rd0), 32'd1);
      check("R2 entry address", 32'(last_ra), 32'(BASE + 16'(v << 1)));
      if (w[15]) begin
        check("R1 paddr", 32'(r_pa), 32'({w[7:0], va[3:0]}));
        check("R3 no fault", 32'({r_pf, r_pr}), 32'd0);
      end else begin
        check("R4 page fault", 32'({r_pf, r_pr}), 32'b10);
        check("R4 fault vaddr", 32'(r_va), 32'(va));
        check("R4 paddr zero", 32'(r_pa), 32'd0);
      end
      rd0 = n_rd;
      access(va ^ 12'h009, 1'b0);
      if (w[15]) begin
        check("R3 rehit no walk", 32'(n_rd - rd0), 32'd0);
        check("R1 rehit paddr", 32'(r_pa), 32'({w[7:0], va[3:0] ^ 4'h9}));
      end else begin
        check("R4 not cached", 32'(n_rd - rd0), 32'd1);
      end
    end

    // R8 flush then R7 round robin
    do_flush();
    rd0 = n_rd;
    access(12'h010, 1'b0);
    check("R8 walk after flush", 32'(n_rd - rd0), 32'd1);
    do_flush();
    k = 0;
    for (int v = 20; v < 60 && k < 9; v++) if ((v % 5) != 3) begin pg[k] = v; k++; end
    for (int j = 0; j < 9; j++) access({8'(pg[j]), 4'h0}, 1'b0);
    rd0 = n_rd;
    for (int j = 1; j < 9; j++) access({8'(pg[j]), 4'h1}, 1'b0);
    check("R7 survivors hit", 32'(n_rd - rd0), 32'd0);
    rd0 = n_rd;
    access({8'(pg[0]), 4'h2}, 1'b0);
    check("R7 oldest evicted", 32'(n_rd - rd0), 32'd1);
    check("R7 refill paddr", 32'(r_pa), 32'({8'(pg[0]) ^ 8'hA5, 4'h2}));

    // R5 protection: page 0 is resident and read-only
    wr0 = n_wr;
    access(12'h00C, 1'b1);
    check("R5 prot fault", 32'({r_pf, r_pr}), 32'b01);
    check("R5 paddr zero", 32'(r_pa), 32'd0);
    check("R5 no mem write", 32'(n_wr - wr0), 32'd0);
    access(12'h00C, 1'b0);
    check("R5 read ok", 32'(r_pa), 32'({8'hA5, 4'hC}));

    // R6 dirty write-back: page 1 writable and clean, page 14 already dirty
    wr0 = n_wr;
    access(12'h013, 1'b1);
    check("R6 write paddr", 32'(r_pa), 32'({8'h01 ^ 8'hA5, 4'h3}));
    check("R6 one write-back", 32'(n_wr - wr0), 32'd1);
    check("R6 wb address", 32'(last_wa), 32'(BASE + 16'd2));
    check("R6 wb data", 32'(last_wd), 32'({4'b1111, 4'b0000, 8'h01 ^ 8'hA5}));
    wr0 = n_wr;
    access(12'h015, 1'b1);
    check("R6 second write no wb", 32'(n_wr - wr0), 32'd0);
    wr0 = n_wr;
    access(12'h0E1, 1'b1);
    check("R6 dirty page no wb", 32'(n_wr - wr0), 32'd0);
    check("R6 dirty page paddr", 32'(r_pa), 32'({8'd14 ^ 8'hA5, 4'h1}));

    // R4 write to non-resident page 3 faults as page fault
    access(12'h037, 1'b1);
    check("R4 write page fault", 32'({r_pf, r_pr}), 32'b10);
    check("R4 write fault vaddr", 32'(r_va), 32'h037);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule